// File: doc/BRIEF.md
# I2C Serial Memory Write Target

This block is a target on a two-wire serial bus that accepts byte writes and page writes into an on-chip byte array. SCL and SDA arrive as open-drain line levels and are oversampled by the system clock. SDA is pulled low only through `sda_oe_o`. A write transaction has this shape: a start condition, a device address byte that carries a write direction bit, two word-address bytes with the high byte first, and one or more data bytes. Data bytes collect in a page buffer. On the stop condition that buffer is committed into the array.

The commit runs inside a self-timed write cycle of a fixed number of system clocks. For the whole of that cycle the target ignores the bus entirely. A controller finds out that the cycle has ended by acknowledge polling: it sends a start and the device address repeatedly, and the first acknowledge shows that the target is free again. Data bytes advance only the in-page offset, so a long burst wraps inside its own page. A port on the array side reads the stored bytes back combinationally.

Top module: `i2c_wr_target`

## Requirements
- R1: A device address byte whose upper seven bits equal `DEV_ADDR` and whose bit 0 is 0 (write) is acknowledged. SDA is held low from the SCL falling edge after the eighth bit until the SCL falling edge after the ninth. Any other address byte, including a read request (bit 0 = 1), gets no acknowledge, and the bus is ignored until the next start. After reset `sda_oe_o` is 0.
- R2: After an acknowledged device address, two word-address bytes are received, high byte first, and each one is acknowledged. The target word address is the low `ADDR_W` bits of {high, low}. Higher bits of the high byte are ignored.
- R3: Every received data byte is acknowledged during the ninth clock.
- R4: A stop that follows a single data byte writes that byte at the word address.
- R5: Each data byte advances only the low `PAGE_W` bits of the address. After the last byte of a page, the next byte goes to the first byte of the same page.
- R6: When more than 2^`PAGE_W` data bytes are sent, later bytes overwrite earlier ones at the same offset, and the last byte received at each offset is the one stored.
- R7: The commit writes only the offsets that received data. All other bytes of the page keep their previous contents.
- R8: A stop after at least one data byte starts a busy period of exactly `T_WR_CYC` clocks. During that period nothing is acknowledged, and a complete write attempted on the bus changes no memory byte.
- R9: Once the busy period is over, the device address is acknowledged again (acknowledge polling).
- R10: A stop that comes before any data byte (after only the device address, or after only one or two word-address bytes) writes nothing and starts no busy period. A device address sent right after such a stop is acknowledged.
- R11: A start or a stop seen after two or more bits of a byte have been clocked in aborts the transaction without acknowledging and without writing. An abort by start leaves the target ignoring the bus until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | Pull SDA low when 1 (acknowledge) |
| mem_raddr_i | input | ADDR_W | Array read address |
| mem_rdata_o | output | 8 | Array byte at `mem_raddr_i` |

## Verification
A wrong state or a wrong bit count shows up on `sda_oe_o` within one byte time. The acknowledge then lands in the wrong ninth clock or does not come at all, and the bench checks every acknowledge slot. A wrong page offset, a missed wrap, or a commit of unreceived offsets becomes visible only once the busy period has ended, so the bench compares whole pages against its own model after each poll succeeds. A busy period that is too short or too long shows in how the early polls are answered, and the checker measures its length exactly in clocks.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADRH,
    ST_ADRL,
    ST_DATA,
    ST_BUSY
  } wr_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_W-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  assign scl_s = scl_ff[SYNC_W-1];
  assign sda_s = sda_ff[SYNC_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_W-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_W-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // SDA edges while SCL stays high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_page_buf.sv
module i2c_page_buf #(
  parameter int PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [PAGE_W-1:0] wr_idx_i,
  input  logic [7:0]        wr_data_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_vld_o,
  output logic              any_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [7:0]            data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) data_q[wr_idx_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= '0;
    else if (clr_i)   vld_q <= '0;
    else if (wr_en_i) vld_q[wr_idx_i] <= 1'b1;
  end

  assign rd_data_o = data_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];
  assign any_o     = |vld_q;
endmodule

// File: rtl/i2c_byte_array.sv
module i2c_byte_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
  import i2c_wr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 6,
  parameter int T_WR_CYC = 2000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] mem_raddr_i,
  output logic [7:0]        mem_rdata_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int ROW_W      = ADDR_W - PAGE_W;
  localparam int HI_W       = ADDR_W - 8;
  localparam int CNT_W      = $clog2(T_WR_CYC + PAGE_BYTES + 1);

  wr_state_e         state_q;
  logic [3:0]        bcnt_q;
  logic [7:0]        shreg_q;
  logic              ack_q;
  logic [HI_W-1:0]   addr_hi_q;
  logic [ROW_W-1:0]  row_q;
  logic [PAGE_W-1:0] off_q;
  logic [CNT_W-1:0]  wcnt_q;

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic active, byte_done, mid_byte, busy_end, dev_hit;
  logic buf_we, buf_clr, buf_vld, buf_any, mem_we;
  logic [7:0] buf_rdata;

  i2c_line_sync #(.SYNC_W(2)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  assign active    = (state_q != ST_IDLE) && (state_q != ST_BUSY);
  assign mid_byte  = bcnt_q >= 4'd2;
  assign byte_done = active && !start_ev && !stop_ev && scl_fall && (bcnt_q == 4'd8);
  assign dev_hit   = (shreg_q[7:1] == DEV_ADDR) && !shreg_q[0];
  assign busy_end  = (state_q == ST_BUSY) && (wcnt_q == CNT_W'(T_WR_CYC - 1));
  assign buf_we    = byte_done && (state_q == ST_DATA);
  assign buf_clr   = (start_ev && state_q != ST_BUSY) || busy_end;
  // commit sweeps the page during the first PAGE_BYTES busy cycles
  assign mem_we    = (state_q == ST_BUSY) && (wcnt_q < CNT_W'(PAGE_BYTES)) && buf_vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bcnt_q    <= '0;
      shreg_q   <= '0;
      ack_q     <= 1'b0;
      addr_hi_q <= '0;
      row_q     <= '0;
      off_q     <= '0;
      wcnt_q    <= '0;
    end else if (state_q == ST_BUSY) begin
      ack_q  <= 1'b0;
      wcnt_q <= wcnt_q + CNT_W'(1);
      if (busy_end) begin
        state_q <= ST_IDLE;
        wcnt_q  <= '0;
      end
    end else if (start_ev) begin
      ack_q   <= 1'b0;
      bcnt_q  <= '0;
      state_q <= (state_q == ST_IDLE || !mid_byte) ? ST_DEV : ST_IDLE;
    end else if (stop_ev) begin
      ack_q  <= 1'b0;
      bcnt_q <= '0;
      wcnt_q <= '0;
      if (state_q == ST_DATA && !mid_byte && buf_any) state_q <= ST_BUSY;
      else                                              state_q <= ST_IDLE;
    end else if (active) begin
      if (scl_rise && bcnt_q < 4'd8) begin
        shreg_q <= {shreg_q[6:0], sda_s};
        bcnt_q  <= bcnt_q + 4'd1;
      end else if (byte_done) begin
        bcnt_q <= 4'd9;
        ack_q  <= 1'b1;
        unique case (state_q)
          ST_DEV: begin
            if (dev_hit) state_q <= ST_ADRH;
            else begin
              state_q <= ST_IDLE;
              bcnt_q  <= '0;
              ack_q   <= 1'b0;
            end
          end
          ST_ADRH: begin
            addr_hi_q <= shreg_q[HI_W-1:0];
            state_q   <= ST_ADRL;
          end
          ST_ADRL: begin
            {row_q, off_q} <= {addr_hi_q, shreg_q};
            state_q        <= ST_DATA;
          end
          default: off_q <= off_q + PAGE_W'(1);
        endcase
      end else if (scl_fall && bcnt_q == 4'd9) begin
        ack_q  <= 1'b0;
        bcnt_q <= '0;
      end
    end
  end

  i2c_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (buf_clr),
    .wr_en_i   (buf_we),
    .wr_idx_i  (off_q),
    .wr_data_i (shreg_q),
    .rd_idx_i  (wcnt_q[PAGE_W-1:0]),
    .rd_data_o (buf_rdata),
    .rd_vld_o  (buf_vld),
    .any_o     (buf_any)
  );

  i2c_byte_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i ({row_q, wcnt_q[PAGE_W-1:0]}),
    .wdata_i (buf_rdata),
    .raddr_i (mem_raddr_i),
    .rdata_o (mem_rdata_o)
  );

  assign sda_oe_o = ack_q;
endmodule

// File: rtl/i2c_wr_target_chk.sv
module i2c_wr_target_chk #(
  parameter int T_WR_CYC = 2000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sda_oe_o,
  input logic busy_i,
  input logic buf_any_i,
  input logic scl_fall_i,
  input logic start_i,
  input logic stop_i
);
  int unsigned busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= 0;
    else if (busy_i) busy_cnt <= busy_cnt + 1;
    else             busy_cnt <= 0;
  end

  a_r8_busy_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sda_oe_o);

  a_r8_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && busy_cnt < T_WR_CYC - 1) |=> busy_i);

  a_r8_busy_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && busy_cnt == T_WR_CYC - 1) |=> !busy_i);

  a_r10_no_empty_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> buf_any_i);

  a_r1_ack_on_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall_i));

  a_r1_ack_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> ($past(scl_fall_i) || $past(start_i) || $past(stop_i)));
endmodule

bind i2c_wr_target i2c_wr_target_chk #(.T_WR_CYC(T_WR_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sda_oe_o   (sda_oe_o),
  .busy_i     (state_q == i2c_wr_pkg::ST_BUSY),
  .buf_any_i  (buf_any),
  .scl_fall_i (scl_fall),
  .start_i    (start_ev),
  .stop_i     (stop_ev)
);

// File: tb/sim_i2c_wr_target.sv
`timescale 1ns/1ps
module sim_i2c_wr_target;
  localparam int ADDR_W = 10;
  localparam int H      = 8;
  localparam logic [7:0] DEV_W = 8'hA0;  // 7'h50, write

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [ADDR_W-1:0] raddr = '0;
  logic [7:0] rdata;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [7:0] ref_mem [1024];
  bit         ref_ok  [1024];

  always #2 clk = ~clk;
  assign sda_line = sda_drv & ~sda_oe;

  i2c_wr_target u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .sda_oe_o    (sda_oe),
    .mem_raddr_i (raddr),
    .mem_rdata_o (rdata)
  );

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; hw(H);
    scl = 1'b1;     hw(H);
    sda_drv = 1'b0; hw(H);
    scl = 1'b0;     hw(H);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; hw(H);
    scl = 1'b1;     hw(H);
    sda_drv = 1'b1; hw(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; hw(H);
      scl = 1'b1;     hw(H);
      scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_drv = 1'b1; hw(H);
    scl = 1'b1;     hw(H/2);
    acked = sda_oe;
    hw(H/2);
    scl = 1'b0;     hw(H/2);
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
    return seed + 8'(k * 7);
  endfunction

  // full write; returns count of acknowledged bytes
  task automatic write_seq(input logic [15:0] a, input int n, input logic [7:0] seed,
                           input bit model, output int nack_ok);
    bit ak;
    logic [ADDR_W-1:0] wa;
    nack_ok = 0;
    bus_start();
    send_byte(DEV_W, ak);   nack_ok += int'(ak);
    send_byte(a[15:8], ak); nack_ok += int'(ak);
    send_byte(a[7:0], ak);  nack_ok += int'(ak);
    wa = a[ADDR_W-1:0];
    for (int k = 0; k < n; k++) begin
      send_byte(pat(seed, k), ak); nack_ok += int'(ak);
      if (model) begin
        ref_mem[wa] = pat(seed, k);
        ref_ok[wa]  = 1'b1;
      end
      wa[5:0] = wa[5:0] + 6'd1;
    end
    bus_stop();
  endtask

  task automatic poll_once(output bit ak);
    bus_start();
    send_byte(DEV_W, ak);
    bus_stop();
  endtask

  task automatic wait_ready(input string req, output int polls);
    bit ak;
    polls = 0;
    ak = 0;
    while (!ak && polls < 60) begin
      poll_once(ak);
      polls++;
    end
    check(req, 32'(ak), 32'd1);
  endtask

  task automatic check_row(input string req, input int row);
    for (int o = 0; o < 64; o++) begin
      if (ref_ok[row*64 + o]) begin
        raddr = ADDR_W'(row*64 + o);
        hw(1);
        check(req, {24'd0, rdata}, {24'd0, ref_mem[row*64 + o]});
      end
    end
  endtask

  task automatic t_reset();
    check("R1 reset idle", 32'(sda_oe), 32'd0);
  endtask

  task automatic t_byte_write();
    int n, polls;
    bit ak;
    // high byte 0xFD: only its low 2 bits count -> address 0x145
    write_seq(16'hFD45, 1, 8'h3C, 1, n);
    check("R1 R2 R3 byte write acks", 32'(n), 32'd4);
    poll_once(ak);
    check("R8 no ack while busy", 32'(ak), 32'd0);
    wait_ready("R9 ack after write cycle", polls);
    raddr = 10'h145; hw(1);
    check("R2 R4 byte stored", {24'd0, rdata}, 32'h3C);
  endtask

  task automatic t_full_page();
    int n, polls;
    write_seq(16'h00C0, 64, 8'h11, 1, n);
    check("R3 page acks", 32'(n), 32'd67);
    wait_ready("R9 ready", polls);
    check_row("R5 full page", 3);
  endtask

  task automatic t_wrap_partial();
    int n, polls;
    write_seq(16'h00FE, 3, 8'h90, 1, n);
    wait_ready("R9 ready", polls);
    raddr = 10'h0C0; hw(1);
    check("R5 wrap to page start", {24'd0, rdata}, {24'd0, pat(8'h90, 2)});
    check_row("R7 rest of page kept", 3);
  endtask

  task automatic t_overflow();
    int n, polls;
    write_seq(16'h0150, 66, 8'h05, 1, n);
    check("R3 overflow acks", 32'(n), 32'd69);
    wait_ready("R9 ready", polls);
    raddr = 10'h150; hw(1);
    check("R6 last byte wins", {24'd0, rdata}, {24'd0, pat(8'h05, 64)});
    check_row("R6 overflow page", 5);
  endtask

  task automatic t_bad_addr();
    bit ak;
    int polls;
    bus_start();
    send_byte(8'hA2, ak);
    check("R1 wrong address nack", 32'(ak), 32'd0);
    send_byte(8'h00, ak);
    check("R1 ignored after nack", 32'(ak), 32'd0);
    send_byte(8'hC5, ak);
    send_byte(8'hEE, ak);
    bus_stop();
    bus_start();
    send_byte(8'hA1, ak);
    check("R1 read request nack", 32'(ak), 32'd0);
    bus_stop();
    poll_once(ak);
    check("R1 no write cycle started", 32'(ak), 32'd1);
    wait_ready("R9 ready", polls);
    check_row("R1 memory untouched", 3);
  endtask

  task automatic t_early_stop();
    bit ak;
    bus_start(); send_byte(DEV_W, ak); send_byte(8'h00, ak); bus_stop();
    poll_once(ak);
    check("R10 stop after high byte", 32'(ak), 32'd1);
    bus_start(); send_byte(DEV_W, ak); send_byte(8'h00, ak); send_byte(8'hC4, ak); bus_stop();
    poll_once(ak);
    check("R10 stop after word address", 32'(ak), 32'd1);
    check_row("R10 memory untouched", 3);
  endtask

  task automatic t_mid_byte();
    bit ak;
    bus_start(); send_byte(DEV_W, ak); send_byte(8'h00, ak); send_byte(8'hC8, ak);
    send_byte(8'h77, ak);
    check("R3 data ack before abort", 32'(ak), 32'd1);
    send_bits(8'hFF, 3);
    bus_stop();
    poll_once(ak);
    check("R11 stop mid-byte aborts", 32'(ak), 32'd1);
    check_row("R11 no write on stop abort", 3);
    bus_start(); send_byte(DEV_W, ak); send_byte(8'h00, ak); send_byte(8'hC9, ak);
    send_bits(8'hFF, 3);
    bus_start();
    send_byte(DEV_W, ak);
    check("R11 start mid-byte idles", 32'(ak), 32'd0);
    bus_stop();
    poll_once(ak);
    check("R11 no write cycle after abort", 32'(ak), 32'd1);
    check_row("R11 no write on start abort", 3);
  endtask

  task automatic t_busy_ignore();
    int n, polls;
    write_seq(16'h0200, 1, 8'h5A, 1, n);
    write_seq(16'h0210, 2, 8'hE1, 0, n);
    check("R8 busy acks nothing", 32'(n), 32'd0);
    wait_ready("R9 ready after busy", polls);
    check("R8 poll saw busy first", 32'(polls > 1), 32'd1);
    ref_ok[10'h210] = 1'b1; ref_mem[10'h210] = 8'h00;
    raddr = 10'h200; hw(1);
    check("R4 write before busy stored", {24'd0, rdata}, 32'h5A);
    // give 0x210 a known value, then confirm the ignored write left it
    write_seq(16'h0210, 1, 8'h44, 1, n);
    wait_ready("R9 ready", polls);
    write_seq(16'h0211, 1, 8'h99, 1, n);
    write_seq(16'h0210, 1, 8'hBB, 0, n);
    wait_ready("R9 ready", polls);
    raddr = 10'h210; hw(1);
    check("R8 write during busy dropped", {24'd0, rdata}, 32'h44);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      ref_mem[i] = 8'h00;
      ref_ok[i]  = 1'b0;
    end
    hw(5);
    rst_ni = 1'b1;
    hw(5);
    t_reset();
    t_byte_write();
    t_full_page();
    t_wrap_partial();
    t_overflow();
    t_bad_addr();
    t_early_stop();
    t_mid_byte();
    t_busy_ignore();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  end
endmodule